// File: doc/BRIEF.md
# Mailbox Handshake with Region Lock

This block sits between a producer and a consumer that share one exchange memory. The producer hands over a finished data block by posting a mail that carries the block's start address and length. Posting does two things. It queues the mail toward the consumer, and it locks the described address range against further producer writes, so new output cannot overwrite data that has not been taken yet.

The consumer sees a pending mail as a notification level. It reads the head mail and pops it. A consumer that waits for a mail simply stalls until the notification rises. Once it has copied the whole block into its own local memory, and before any processing, it returns a release mail naming the region's tag. When the producer consumes that release, the region is unlocked and its slot is free for the next block. Two regions can be held at once, so the producer can fill one buffer while the consumer copies the other. Each mail direction is buffered in a small FIFO that reports full and empty.

Top module: `mbx_region_lock`

## Requirements
- R1: After reset both FIFOs report empty and not full, no mail or release is pending, `viol_o` is 0, `post_ready_o` is 1, and a write to any address is granted.
- R2: A post taken while `post_ready_o` is high appears at the consumer on the next cycle with the same address and size. Mails leave in the order they were posted, and `mail_pop_i` removes the head mail.
- R3: From the cycle after a post is taken, a write with `wr_addr_i` in [addr, addr+size) gets `wr_ok_o`=0, and writes outside every locked range get `wr_ok_o`=1. `wr_ok_o` is never high without `wr_valid_i`.
- R4: A blocked write sets `viol_o` on the next cycle, and `viol_o` stays at 1 until reset. Granted writes never set it.
- R5: At most two regions are locked at once. While both are held, `post_ready_o` is 0 and a held post stays pending. It is taken on the first cycle a slot is free.
- R6: A release mail pushed by the consumer becomes visible to the producer on the next cycle with its tag. The region stays locked while the release is queued. When the producer pops the release, that region unlocks on the next cycle and the other region stays locked.
- R7: Each FIFO holds two entries. `*_full_o` is 1 at two entries and `*_empty_o` is 1 at zero. A push while full is dropped and a pop while empty has no effect.
- R8: A taken post occupies the lowest-numbered free slot, and the mail's tag equals that slot number (0 or 1).
- R9: A region of size 0 occupies a slot but blocks no address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| post_valid_i | input | 1 | Producer posts a block |
| post_addr_i | input | AW | Block start address |
| post_size_i | input | SW | Block length in words |
| post_ready_o | output | 1 | Post can be taken this cycle |
| mail_valid_o | output | 1 | Mail pending for the consumer (notification) |
| mail_addr_o | output | AW | Head mail address |
| mail_size_o | output | SW | Head mail size |
| mail_tag_o | output | TW | Head mail region tag |
| mail_pop_i | input | 1 | Consumer takes head mail |
| rel_push_i | input | 1 | Consumer posts a release mail |
| rel_tag_i | input | TW | Tag of the region being released |
| ack_valid_o | output | 1 | Release pending for the producer |
| ack_tag_o | output | TW | Head release tag |
| ack_pop_i | input | 1 | Producer takes the release, unlocking the region |
| wr_valid_i | input | 1 | Producer write request |
| wr_addr_i | input | AW | Producer write address |
| wr_ok_o | output | 1 | Write granted (not in a locked range) |
| viol_o | output | 1 | Sticky blocked-write flag |
| fwd_full_o | output | 1 | Mail FIFO full |
| fwd_empty_o | output | 1 | Mail FIFO empty |
| rel_full_o | output | 1 | Release FIFO full |
| rel_empty_o | output | 1 | Release FIFO empty |

## Verification
The bench uses the default parameters: 8-bit addresses and sizes, two lock slots and two-entry FIFOs. With 8-bit addresses, one locked region can be probed at every one of the 256 write addresses, and the expected grant is computed from the range bounds. With only two slots and two entries, every full, empty and stall state is reached in a few posts. This covers slot reuse after a release, a held post that waits for a free slot, and a zero-length region.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  localparam int unsigned DEF_AW    = 8;
  localparam int unsigned DEF_SW    = 8;
  localparam int unsigned DEF_NSLOT = 2;
  localparam int unsigned DEF_DEPTH = 2;

  function automatic int unsigned idx_w(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/mbx_fifo.sv
module mbx_fifo #(
  parameter int unsigned W     = 8,
  parameter int unsigned DEPTH = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic [W-1:0] din_i,
  input  logic         pop_i,
  output logic [W-1:0] dout_o,
  output logic         full_o,
  output logic         empty_o
);
  localparam int unsigned PW = mbx_pkg::idx_w(DEPTH);
  localparam int unsigned CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem_q [DEPTH];
  logic [PW-1:0] wptr_q, rptr_q;
  logic [CW-1:0] cnt_q;
  logic          do_push, do_pop;

  assign full_o  = (cnt_q == CW'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign do_push = push_i & ~full_o;
  assign do_pop  = pop_i & ~empty_o;
  assign dout_o  = mem_q[rptr_q];

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else begin
      if (do_push) begin
        mem_q[wptr_q] <= din_i;
        wptr_q        <= nxt(wptr_q);
      end
      if (do_pop) rptr_q <= nxt(rptr_q);
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end
endmodule

// File: rtl/mbx_lock_table.sv
module mbx_lock_table #(
  parameter int unsigned AW    = 8,
  parameter int unsigned SW    = 8,
  parameter int unsigned NSLOT = 2,
  localparam int unsigned TW   = mbx_pkg::idx_w(NSLOT)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          set_i,
  input  logic [TW-1:0] set_slot_i,
  input  logic [AW-1:0] set_base_i,
  input  logic [SW-1:0] set_size_i,
  input  logic          clr_i,
  input  logic [TW-1:0] clr_slot_i,
  input  logic [AW-1:0] probe_addr_i,
  output logic          hit_o,
  output logic [TW-1:0] free_slot_o,
  output logic          any_free_o
);
  localparam int unsigned EW = ((AW > SW) ? AW : SW) + 1;

  logic [NSLOT-1:0] busy_q, hit_v;
  logic [AW-1:0]    base_q [NSLOT];
  logic [SW-1:0]    size_q [NSLOT];

  for (genvar s = 0; s < NSLOT; s++) begin : g_slot
    logic [EW-1:0] lo, hi, pa;
    assign lo = EW'(base_q[s]);
    assign hi = EW'(base_q[s]) + EW'(size_q[s]);
    assign pa = EW'(probe_addr_i);
    assign hit_v[s] = busy_q[s] & (pa >= lo) & (pa < hi);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        busy_q[s] <= 1'b0;
        base_q[s] <= '0;
        size_q[s] <= '0;
      end else if (set_i && set_slot_i == TW'(s)) begin
        busy_q[s] <= 1'b1;
        base_q[s] <= set_base_i;
        size_q[s] <= set_size_i;
      end else if (clr_i && clr_slot_i == TW'(s)) begin
        busy_q[s] <= 1'b0;
      end
    end
  end

  assign hit_o      = |hit_v;
  assign any_free_o = ~&busy_q;

  // lowest free index wins
  always_comb begin
    free_slot_o = '0;
    for (int s = NSLOT - 1; s >= 0; s--)
      if (!busy_q[s]) free_slot_o = TW'(s);
  end
endmodule

// File: rtl/mbx_region_lock.sv
module mbx_region_lock #(
  parameter int unsigned AW    = mbx_pkg::DEF_AW,
  parameter int unsigned SW    = mbx_pkg::DEF_SW,
  parameter int unsigned NSLOT = mbx_pkg::DEF_NSLOT,
  parameter int unsigned DEPTH = mbx_pkg::DEF_DEPTH,
  localparam int unsigned TW   = mbx_pkg::idx_w(NSLOT)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          post_valid_i,
  input  logic [AW-1:0] post_addr_i,
  input  logic [SW-1:0] post_size_i,
  output logic          post_ready_o,
  output logic          mail_valid_o,
  output logic [AW-1:0] mail_addr_o,
  output logic [SW-1:0] mail_size_o,
  output logic [TW-1:0] mail_tag_o,
  input  logic          mail_pop_i,
  input  logic          rel_push_i,
  input  logic [TW-1:0] rel_tag_i,
  output logic          ack_valid_o,
  output logic [TW-1:0] ack_tag_o,
  input  logic          ack_pop_i,
  input  logic          wr_valid_i,
  input  logic [AW-1:0] wr_addr_i,
  output logic          wr_ok_o,
  output logic          viol_o,
  output logic          fwd_full_o,
  output logic          fwd_empty_o,
  output logic          rel_full_o,
  output logic          rel_empty_o
);
  localparam int unsigned MW = TW + AW + SW;

  logic          take, unlock, hit, any_free, viol_q;
  logic [TW-1:0] free_slot;
  logic [MW-1:0] fwd_din, fwd_dout;

  assign post_ready_o = any_free & ~fwd_full_o;
  assign take         = post_valid_i & post_ready_o;
  assign unlock       = ack_pop_i & ~rel_empty_o;
  assign fwd_din      = {free_slot, post_addr_i, post_size_i};
  assign {mail_tag_o, mail_addr_o, mail_size_o} = fwd_dout;
  assign mail_valid_o = ~fwd_empty_o;
  assign ack_valid_o  = ~rel_empty_o;

  mbx_fifo #(.W(MW), .DEPTH(DEPTH)) fwd_fifo_i (
    .clk_i, .rst_ni,
    .push_i (take),       .din_i  (fwd_din),
    .pop_i  (mail_pop_i), .dout_o (fwd_dout),
    .full_o (fwd_full_o), .empty_o(fwd_empty_o)
  );

  mbx_fifo #(.W(TW), .DEPTH(DEPTH)) rel_fifo_i (
    .clk_i, .rst_ni,
    .push_i (rel_push_i), .din_i  (rel_tag_i),
    .pop_i  (ack_pop_i),  .dout_o (ack_tag_o),
    .full_o (rel_full_o), .empty_o(rel_empty_o)
  );

  mbx_lock_table #(.AW(AW), .SW(SW), .NSLOT(NSLOT)) locks_i (
    .clk_i, .rst_ni,
    .set_i        (take),
    .set_slot_i   (free_slot),
    .set_base_i   (post_addr_i),
    .set_size_i   (post_size_i),
    .clr_i        (unlock),
    .clr_slot_i   (ack_tag_o),
    .probe_addr_i (wr_addr_i),
    .hit_o        (hit),
    .free_slot_o  (free_slot),
    .any_free_o   (any_free)
  );

  assign wr_ok_o = wr_valid_i & ~hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                viol_q <= 1'b0;
    else if (wr_valid_i && hit) viol_q <= 1'b1;
  end
  assign viol_o = viol_q;
endmodule

// File: rtl/mbx_region_lock_chk.sv
module mbx_region_lock_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic post_valid_i,
  input logic post_ready_o,
  input logic rel_push_i,
  input logic wr_valid_i,
  input logic wr_ok_o,
  input logic viol_o,
  input logic fwd_full_o,
  input logic fwd_empty_o,
  input logic rel_full_o,
  input logic rel_empty_o
);
  // R2
  post_lands_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    post_valid_i && post_ready_o |=> !fwd_empty_o);
  // R3
  grant_needs_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_ok_o |-> wr_valid_i);
  // R4
  viol_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    viol_o |=> viol_o);
  // R4
  blocked_flags_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_valid_i && !wr_ok_o |=> viol_o);
  // R5
  post_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    post_ready_o |-> !fwd_full_o);
  // R6
  release_lands_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rel_push_i && !rel_full_o |=> !rel_empty_o);
  // R7
  fwd_status_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(fwd_full_o && fwd_empty_o));
  // R7
  rel_status_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rel_full_o && rel_empty_o));
endmodule

bind mbx_region_lock mbx_region_lock_chk chk_i (
  .clk_i, .rst_ni, .post_valid_i, .post_ready_o, .rel_push_i,
  .wr_valid_i, .wr_ok_o, .viol_o, .fwd_full_o, .fwd_empty_o,
  .rel_full_o, .rel_empty_o
);

// File: tb/mbx_region_lock_tb_top.sv
module mbx_region_lock_tb_top;
  logic       clk_i = 1'b0, rst_ni = 1'b0;
  logic       post_valid_i = 0, mail_pop_i = 0, rel_push_i = 0, ack_pop_i = 0, wr_valid_i = 0;
  logic [7:0] post_addr_i = 0, post_size_i = 0, wr_addr_i = 0;
  logic [0:0] rel_tag_i = 0;
  logic       post_ready_o, mail_valid_o, ack_valid_o, wr_ok_o, viol_o;
  logic [7:0] mail_addr_o, mail_size_o;
  logic [0:0] mail_tag_o, ack_tag_o;
  logic       fwd_full_o, fwd_empty_o, rel_full_o, rel_empty_o;
  int         n_run = 0, n_fail = 0;

  always #2 clk_i = ~clk_i;

  mbx_region_lock dut_i (.*);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic eq(input string req, input int act, input int exp);
    chk(act == exp, req, act, exp);
  endtask

  task automatic tick();
    @(posedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic probe(input string req, input int a, input int exp);
    wr_valid_i = 1; wr_addr_i = 8'(a);
    #1 eq(req, int'(wr_ok_o), exp);
    tick();
    wr_valid_i = 0;
  endtask

  task automatic post(input int a, input int s);
    post_valid_i = 1; post_addr_i = 8'(a); post_size_i = 8'(s);
    tick();
    post_valid_i = 0;
  endtask

  initial begin
    #800000;
    n_fail++;
    $display("FAIL watchdog act=0 exp=1");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    @(negedge clk_i); @(negedge clk_i);
    rst_ni = 1;
    @(negedge clk_i);
    // R1 reset state
    eq("R1 fwd_empty", int'(fwd_empty_o), 1);
    eq("R1 fwd_full",  int'(fwd_full_o), 0);
    eq("R1 rel_empty", int'(rel_empty_o), 1);
    eq("R1 rel_full",  int'(rel_full_o), 0);
    eq("R1 mail_valid", int'(mail_valid_o), 0);
    eq("R1 ack_valid", int'(ack_valid_o), 0);
    eq("R1 viol", int'(viol_o), 0);
    eq("R1 post_ready", int'(post_ready_o), 1);
    wr_valid_i = 1; wr_addr_i = 8'd16;
    #1 eq("R1 wr_ok", int'(wr_ok_o), 1);
    wr_valid_i = 0;

    // R2 R8 first post
    post(16, 4);
    eq("R2 mail_valid", int'(mail_valid_o), 1);
    eq("R2 addr", int'(mail_addr_o), 16);
    eq("R2 size", int'(mail_size_o), 4);
    eq("R8 tag0", int'(mail_tag_o), 0);

    // R3 R4 full address sweep against one locked range
    for (int a = 0; a < 256; a++) begin
      probe("R3 sweep", a, (a >= 16 && a < 20) ? 0 : 1);
      if (a == 15) eq("R4 granted no viol", int'(viol_o), 0);
      if (a == 16) eq("R4 viol set", int'(viol_o), 1);
    end

    // R5 R7 second region fills both slots and the mail FIFO
    post(100, 16);
    eq("R7 fwd_full", int'(fwd_full_o), 1);
    eq("R5 ready low", int'(post_ready_o), 0);
    post_valid_i = 1; post_addr_i = 8'd200; post_size_i = 8'd2;
    tick(); tick(); tick();
    eq("R7 push while full dropped", int'(mail_addr_o), 16);
    mail_pop_i = 1; tick(); mail_pop_i = 0;
    eq("R2 order addr", int'(mail_addr_o), 100);
    eq("R8 tag1", int'(mail_tag_o), 1);
    eq("R5 slots full ready", int'(post_ready_o), 0);

    // R6 release of region 0
    rel_tag_i = 0; rel_push_i = 1; tick(); rel_push_i = 0;
    eq("R6 ack_valid", int'(ack_valid_o), 1);
    eq("R6 ack_tag", int'(ack_tag_o), 0);
    probe("R6 locked while queued", 17, 0);
    eq("R5 still stalled", int'(post_ready_o), 0);
    ack_pop_i = 1; tick(); ack_pop_i = 0;
    eq("R5 ready after unlock", int'(post_ready_o), 1);
    wr_valid_i = 1; wr_addr_i = 8'd16;
    #1 eq("R6 unlocked", int'(wr_ok_o), 1);
    wr_addr_i = 8'd115;
    #1 eq("R6 other kept", int'(wr_ok_o), 0);
    wr_valid_i = 0;
    tick();  // held post now taken
    post_valid_i = 0;
    mail_pop_i = 1; tick(); mail_pop_i = 0;
    eq("R5 held post addr", int'(mail_addr_o), 200);
    eq("R8 reuse slot0", int'(mail_tag_o), 0);
    mail_pop_i = 1; tick(); mail_pop_i = 0;
    eq("R7 fwd empty", int'(fwd_empty_o), 1);
    mail_pop_i = 1; tick(); mail_pop_i = 0;
    eq("R7 pop empty no effect", int'(fwd_empty_o), 1);
    eq("R7 pop empty full", int'(fwd_full_o), 0);

    // R9 zero-size region
    rel_tag_i = 1; rel_push_i = 1; tick(); rel_push_i = 0;
    ack_pop_i = 1; tick(); ack_pop_i = 0;
    post(50, 0);
    eq("R8 slot1 free", int'(mail_tag_o), 1);
    eq("R9 size0", int'(mail_size_o), 0);
    mail_pop_i = 1; tick(); mail_pop_i = 0;
    probe("R9 zero blocks none", 50, 1);
    probe("R3 slot0 held", 201, 0);
    probe("R3 end exclusive", 202, 1);

    // R7 release FIFO depth
    rel_push_i = 1; rel_tag_i = 0; tick();
    rel_tag_i = 1; tick();
    eq("R7 rel_full", int'(rel_full_o), 1);
    rel_tag_i = 0; tick(); rel_push_i = 0;
    eq("R7 rel head", int'(ack_tag_o), 0);
    ack_pop_i = 1; tick();
    eq("R7 rel second", int'(ack_tag_o), 1);
    tick();
    eq("R7 rel drained", int'(rel_empty_o), 1);
    tick(); ack_pop_i = 0;
    eq("R7 rel pop empty", int'(rel_empty_o), 1);
    eq("R7 rel not full", int'(rel_full_o), 0);
    eq("R6 all free ready", int'(post_ready_o), 1);
    probe("R6 all unlocked", 200, 1);
    eq("R4 sticky", int'(viol_o), 1);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule